// File: doc/BRIEF.md
# Random Word Fetch Unit with Bounded Retry

This block sits between a requester and a hardware random source whose ready flag may drop from time to time. A one-cycle request pulse starts a fetch. The block samples the source's ready flag and data word and returns a 16-, 32- or 64-bit result. The width comes from a size code that is captured with the request. Alongside the result it returns a carry-style valid flag and five further status flags, which are always cleared. When the source is not ready, the result is zero and valid is low.

In single-shot mode the block makes exactly one sampling attempt. In retry mode it samples once per clock until it sees ready, up to a fixed attempt limit (ten by default). If every attempt fails it reports a limit-exceeded status. Each completion is marked by a one-cycle done pulse, together with the number of attempts used. The result and status outputs keep their values until the next completion.

The control is a two-state machine. ST_IDLE goes to ST_SAMPLE on the transition "accept", taken when a request arrives. ST_SAMPLE stays in ST_SAMPLE on "retry", taken in retry mode when ready is low and attempts remain. ST_SAMPLE returns to ST_IDLE on "hit", when ready is seen, or on "give_up", when ready is low and either the block is in single-shot mode or this was the last allowed attempt.

Top module: `rng_fetch_unit`

## Requirements
- R1: When the source ready flag is 1 at an attempt, the fetch completes on that attempt: done_o pulses, carry_o is 1, and word_o holds the source data at the selected width.
- R2: When a fetch completes without ready having been seen, word_o is all zeros and carry_o is 0.
- R3: ovf_o, sign_o, zero_o, aux_o and parity_o are 0 after reset and after every completion, whether the fetch succeeded or failed.
- R4: The size code is captured with the request. Code 0 selects 16 bits, code 1 selects 32 bits, code 2 selects 64 bits, and code 3 falls back to the default of 32 bits. Result bits above the selected width are 0.
- R5: In retry mode (retry_en_i=1), one attempt is made per clock, and the fetch succeeds on the first attempt that sees ready. done_o is high exactly n cycles after the request edge, where n is the number of attempts used, and attempts_o reports n.
- R6: In retry mode, if all MAX_TRIES attempts fail, then done_o rises exactly MAX_TRIES cycles after the request edge, with limit_hit_o=1, carry_o=0, word_o=0 and attempts_o=MAX_TRIES.
- R7: In single-shot mode (retry_en_i=0), exactly one attempt is made. done_o is high one cycle after the request edge, with attempts_o=1 and limit_hit_o=0.
- R8: done_o is a single-cycle pulse, and requests that arrive while a fetch is in progress are ignored. Such a request changes neither the captured size nor the mode, and it produces no additional completion.
- R9: After reset, done_o, carry_o, limit_hit_o, word_o and attempts_o are all 0.
- R10: word_o and all status outputs hold their values between completions, regardless of changes on the source inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Fetch request, accepted when idle |
| size_i | input | 2 | Result width code (0:16, 1:32, 2:64, 3:32) |
| retry_en_i | input | 1 | 1 selects bounded retry, 0 selects single shot |
| src_ready_i | input | 1 | Random source has data |
| src_data_i | input | DATA_W | Random source data word |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | DATA_W | Result word, zero above the width |
| carry_o | output | 1 | Result valid |
| ovf_o | output | 1 | Overflow flag, always cleared |
| sign_o | output | 1 | Sign flag, always cleared |
| zero_o | output | 1 | Zero flag, always cleared |
| aux_o | output | 1 | Auxiliary-carry flag, always cleared |
| parity_o | output | 1 | Parity flag, always cleared |
| limit_hit_o | output | 1 | Retry limit exceeded |
| attempts_o | output | CNT_W | Attempts used by the last fetch |

## Verification
If the attempt counter is off by one, it shows at the completion edge. done_o arrives a cycle early or late relative to the request, and attempts_o or limit_hit_o is wrong on the same pulse. A stuck state machine shows within one cycle after a request, either as a missing done_o or as a second done_o pulse. A wrong captured size or mode shows on the next completion, as non-zero upper result bits or the wrong number of attempts. Output registers that are updated outside completions show as word_o changing while done_o is low.

// File: rtl/rng_fetch_pkg.sv
package rng_fetch_pkg;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_DEF = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SAMPLE = 1'b1
    } state_e;

    localparam int LANE_W = 16;

endpackage

// File: rtl/rng_word_shaper.sv
module rng_word_shaper
    import rng_fetch_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  size_e              size_i,
    input  logic               ready_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [DATA_W-1:0]  word_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic [2:0] lanes_live;

    always_comb begin
        unique case (size_i)
            SZ_16:   lanes_live = 3'd1;
            SZ_64:   lanes_live = 3'd4;
            default: lanes_live = 3'd2;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*LANE_W +: LANE_W] =
            (ready_i && (g < int'(lanes_live))) ? data_i[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/rng_attempt_ctr.sv
module rng_attempt_ctr #(
    parameter int MAX_TRIES = 10,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_TRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (step_i) begin
            count_o <= count_o + 1'b1;
        end
    end

    assign last_o = (count_o == LAST_VAL);

endmodule

// File: rtl/rng_fetch_unit.sv
module rng_fetch_unit
    import rng_fetch_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MAX_TRIES = 10,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        size_i,
    input  logic              retry_en_i,
    input  logic              src_ready_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              sign_o,
    output logic              zero_o,
    output logic              aux_o,
    output logic              parity_o,
    output logic              limit_hit_o,
    output logic [CNT_W-1:0]  attempts_o
);
    state_e state_q, state_d;
    size_e  size_q;
    logic   retry_q;

    logic              accept, attempt, hit, give_up, finish;
    logic [CNT_W-1:0]  tries;
    logic              tries_last;
    logic [DATA_W-1:0] shaped;

    assign accept  = (state_q == ST_IDLE) && req_i;
    assign attempt = (state_q == ST_SAMPLE);
    assign hit     = attempt && src_ready_i;
    assign give_up = attempt && !src_ready_i && (!retry_q || tries_last);
    assign finish  = hit || give_up;

    rng_attempt_ctr #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (attempt),
        .count_o (tries),
        .last_o  (tries_last)
    );

    rng_word_shaper #(.DATA_W(DATA_W)) u_shaper (
        .size_i  (size_q),
        .ready_i (src_ready_i),
        .data_i  (src_data_i),
        .word_o  (shaped)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SAMPLE;
            ST_SAMPLE: if (finish) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= SZ_32;
            retry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                size_q  <= size_e'(size_i);
                retry_q <= retry_en_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            word_o      <= '0;
            carry_o     <= 1'b0;
            ovf_o       <= 1'b0;
            sign_o      <= 1'b0;
            zero_o      <= 1'b0;
            aux_o       <= 1'b0;
            parity_o    <= 1'b0;
            limit_hit_o <= 1'b0;
            attempts_o  <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                word_o      <= shaped;
                carry_o     <= src_ready_i;
                ovf_o       <= 1'b0;
                sign_o      <= 1'b0;
                zero_o      <= 1'b0;
                aux_o       <= 1'b0;
                parity_o    <= 1'b0;
                limit_hit_o <= give_up && retry_q;
                attempts_o  <= tries + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rng_fetch_checker.sv
module rng_fetch_checker #(
    parameter int DATA_W    = 64,
    parameter int MAX_TRIES = 10,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              done_o,
    input logic [DATA_W-1:0] word_o,
    input logic              carry_o,
    input logic              ovf_o,
    input logic              sign_o,
    input logic              zero_o,
    input logic              aux_o,
    input logic              parity_o,
    input logic              limit_hit_o,
    input logic [CNT_W-1:0]  attempts_o
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              busy_q <= 1'b0;
        else if (done_o)         busy_q <= req_i;
        else if (!busy_q && req_i) busy_q <= 1'b1;
    end

    a_r2_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !carry_o) |-> (word_o == '0));

    a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({ovf_o, sign_o, zero_o, aux_o, parity_o} == 5'b0));

    a_r5_attempt_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (attempts_o != '0 && int'(attempts_o) <= MAX_TRIES));

    a_r6_limit_status: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && limit_hit_o) |-> (!carry_o && int'(attempts_o) == MAX_TRIES));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_q);

    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(word_o));

endmodule

bind rng_fetch_unit rng_fetch_checker #(
    .DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_o(done_o),
    .word_o(word_o), .carry_o(carry_o), .ovf_o(ovf_o), .sign_o(sign_o),
    .zero_o(zero_o), .aux_o(aux_o), .parity_o(parity_o),
    .limit_hit_o(limit_hit_o), .attempts_o(attempts_o)
);

// File: tb/rng_fetch_unit_bench.sv
module rng_fetch_unit_bench;
    localparam int CLK_P     = 10;
    localparam int DATA_W    = 64;
    localparam int MAX_TRIES = 10;
    localparam int CNT_W     = $clog2(MAX_TRIES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic [1:0]        size_i = 2'd1;
    logic              retry_en_i = 1'b0;
    logic              src_ready_i = 1'b0;
    logic [DATA_W-1:0] src_data_i = '0;
    logic              done_o, carry_o, ovf_o, sign_o, zero_o, aux_o, parity_o, limit_hit_o;
    logic [DATA_W-1:0] word_o;
    logic [CNT_W-1:0]  attempts_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_P/2) clk = ~clk;

    rng_fetch_unit #(.DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES)) u_rng_fetch_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .size_i(size_i),
        .retry_en_i(retry_en_i), .src_ready_i(src_ready_i), .src_data_i(src_data_i),
        .done_o(done_o), .word_o(word_o), .carry_o(carry_o), .ovf_o(ovf_o),
        .sign_o(sign_o), .zero_o(zero_o), .aux_o(aux_o), .parity_o(parity_o),
        .limit_hit_o(limit_hit_o), .attempts_o(attempts_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] shape(input logic [1:0] sz, input logic [63:0] d);
        case (sz)
            2'd0:    return {48'h0, d[15:0]};
            2'd2:    return d;
            default: return {32'h0, d[31:0]};
        endcase
    endfunction

    // One fetch: source not ready for 'fails' attempts, then ready.
    task automatic run_fetch(input bit mode, input logic [1:0] sz, input int fails,
                             input logic [63:0] data, input bit noise, input string tag);
        int cyc = 0;
        bit ok_done;
        int exp_cyc, exp_att;
        bit exp_carry, exp_lim;
        @(negedge clk);
        req_i = 1'b1; size_i = sz; retry_en_i = mode; src_ready_i = 1'b0;
        @(posedge clk);
        do begin
            @(negedge clk);
            req_i = noise;
            if (noise) begin size_i = ~sz; retry_en_i = ~mode; end
            src_ready_i = (cyc >= fails);
            src_data_i = data;
            @(posedge clk); #1;
            cyc++;
        end while (!done_o && cyc < 40);
        ok_done = done_o;
        @(negedge clk);
        req_i = 1'b0; src_ready_i = 1'b0; src_data_i = ~data;
        exp_att   = mode ? ((fails < MAX_TRIES) ? fails + 1 : MAX_TRIES) : 1;
        exp_cyc   = exp_att;
        exp_carry = mode ? (fails < MAX_TRIES) : (fails == 0);
        exp_lim   = mode && (fails >= MAX_TRIES);
        chk(ok_done && cyc == exp_cyc, {tag, " R5 R7 done cycle"}, 64'(cyc), 64'(exp_cyc));
        chk(carry_o == exp_carry, {tag, " R1 R2 carry"}, 64'(carry_o), 64'(exp_carry));
        chk(word_o == (exp_carry ? shape(sz, data) : 64'h0), {tag, " R1 R2 R4 word"},
            word_o, exp_carry ? shape(sz, data) : 64'h0);
        chk(int'(attempts_o) == exp_att, {tag, " R5 attempts"}, 64'(attempts_o), 64'(exp_att));
        chk(limit_hit_o == exp_lim, {tag, " R6 limit"}, 64'(limit_hit_o), 64'(exp_lim));
        chk({ovf_o, sign_o, zero_o, aux_o, parity_o} == 5'b0, {tag, " R3 flags"},
            64'({ovf_o, sign_o, zero_o, aux_o, parity_o}), 64'h0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(!done_o, {tag, " R8 single pulse"}, 64'(done_o), 64'h0);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(!done_o && !carry_o && !limit_hit_o && word_o == '0 && attempts_o == '0,
            "R9 reset", {word_o[59:0], attempts_o}, 64'h0);
        chk({ovf_o, sign_o, zero_o, aux_o, parity_o} == 5'b0, "R3 reset flags",
            64'({ovf_o, sign_o, zero_o, aux_o, parity_o}), 64'h0);
    endtask

    task automatic t_single();
        run_fetch(1'b0, 2'd1, 0, 64'hDEAD_BEEF_1234_5678, 1'b0, "R7 single ok");
        run_fetch(1'b0, 2'd1, 5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R7 single fail");
    endtask

    task automatic t_sizes();
        run_fetch(1'b0, 2'd0, 0, 64'hA5A5_C3C3_9696_F00D, 1'b0, "R4 size16");
        run_fetch(1'b0, 2'd2, 0, 64'hA5A5_C3C3_9696_F00D, 1'b0, "R4 size64");
        run_fetch(1'b0, 2'd3, 0, 64'hA5A5_C3C3_9696_F00D, 1'b0, "R4 size3");
    endtask

    task automatic t_retry();
        run_fetch(1'b1, 2'd2, 3, 64'h0123_4567_89AB_CDEF, 1'b0, "R5 retry3");
        run_fetch(1'b1, 2'd1, 9, 64'h1111_2222_3333_4444, 1'b0, "R5 retry last");
        run_fetch(1'b1, 2'd2, 99, 64'h5555_6666_7777_8888, 1'b0, "R6 exhausted");
    endtask

    task automatic t_busy();
        run_fetch(1'b1, 2'd0, 4, 64'hCAFE_F00D_BEEF_1357, 1'b1, "R8 busy req");
    endtask

    task automatic t_hold();
        logic [63:0] w;
        run_fetch(1'b0, 2'd2, 0, 64'h0F0F_1E1E_2D2D_3C3C, 1'b0, "R10 setup");
        w = word_o;
        @(negedge clk);
        src_ready_i = 1'b1; src_data_i = 64'h1234_0000_ABCD_9999;
        repeat (4) @(posedge clk);
        #1;
        chk(word_o == w && carry_o && !done_o, "R10 hold", word_o, w);
        @(negedge clk); src_ready_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_single();
        t_sizes();
        t_retry();
        t_busy();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

endmodule